// File: doc/BRIEF.md
# Keyed-Service Watchdog Counter

This block is a watchdog built on a down-counter. It stays idle after reset. Software starts it by writing a start value to its count register, or by writing a fixed service key to its key register when key service is enabled. Once running, the counter steps down by one on every pulse of the tick source the configuration selects. One source is a fast prescaled tick and the other is a slow timer-wrap tick. Each later write to either register re-arms the counter, which is called servicing. Only a reset stops the watchdog.

The output `wd_fire` asserts and stays high until reset in any of these cases: the counter runs out (service too late), the watchdog is serviced twice within one selected tick (service too early), or a wrong key is written while key service is enabled. The configuration register also holds set-only lock bits. Other blocks decode the prescaler, period and timer-control locks from `cfg_state`. This block acts on the configuration lock and the count lock itself.

Register select (`wr_addr`): 0 selects configuration, 1 selects the count, 2 selects the key, and 3 is unused.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, `wd_running` and `wd_fire` are 0, `wd_count` is 0 and `cfg_state` is 0. While idle, the counter holds 0.
- R2: A write to the count register (address 1) with the count lock clear does three things: it stores the value as the reload value, loads `wd_count` with it on the next edge, and sets `wd_running`.
- R3: While running, each pulse of the selected tick lowers `wd_count` by one. Pulses on the tick source that is not selected leave it unchanged.
- R4: Configuration bit 0 selects the tick source: 0 selects `tick_slow` and 1 selects `tick_fast`.
- R5: A selected tick that arrives while `wd_count` is 1 or 0 sets `wd_count` to 0 and raises `wd_fire`.
- R6: When key service is enabled (configuration bit 1 = 1), writing the key 0x5C to address 2 reloads `wd_count` from the stored reload value and sets `wd_running`. This starts the watchdog if it is idle. The reload value resets to the parameter `RESET_LOAD`.
- R7: When key service is enabled, writing any value other than 0x5C to address 2 raises `wd_fire`.
- R8: When key service is disabled, writes to address 2 change neither the counter, `wd_running` nor `wd_fire`.
- R9: A service that follows an earlier service with no selected tick in between raises `wd_fire`. If a selected tick arrives in the same cycle as a service, a new interval begins.
- R10: `wd_running` and `wd_fire` stay high until reset, whatever is written or ticked.
- R11: Configuration bits 2 to 6 are set-only locks. Bit 2 locks the configuration register, so all its bits are ignored. Bit 6 locks the count register, so writes there are ignored and do not start or service the watchdog. Bits 3 to 5 are only held for neighbouring blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Prescaled tick pulse, one clock wide |
| tick_slow | input | 1 | Timer-wrap tick pulse, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | DATA_W (8) | Write data |
| wd_fire | output | 1 | Watchdog signal, sticky until reset |
| wd_running | output | 1 | Watchdog has been started |
| wd_count | output | DATA_W (8) | Current counter value |
| cfg_state | output | 7 | Configuration register, including lock bits |

## Verification
The bench builds the block with `RESET_LOAD` = 6, so a key start from idle loads a small count that differs from every value written through the count register. It also keeps the default 8-bit data width and key 0x5C. Because the reload is small, several key-started and write-started runs fit in a short run. Count values of 0, 1 and 3 are used to reach both ends of the decrement step. A behavioural model runs next to the design on every clock, so the too-early, wrong-key and lock cases are compared cycle by cycle rather than only at their end points.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_CNT  = 2'd1,
    REG_KEY  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CFG_W     = 7;
  localparam int CFG_SRC   = 0;
  localparam int CFG_KEYEN = 1;
  localparam int LOCK_LO   = 2;
  localparam int LOCK_CFG  = 2;
  localparam int LOCK_CNT  = 6;
endpackage

// File: rtl/wdog_cfg_regs.sv
module wdog_cfg_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CFG_W-1:0]  cfg_q
);
  logic cfg_we;
  assign cfg_we = cfg_wr && !cfg_q[LOCK_CFG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q[LOCK_LO-1:0] <= '0;
    end else if (cfg_we) begin
      cfg_q[LOCK_LO-1:0] <= wr_data[LOCK_LO-1:0];
    end
  end

  for (genvar g = LOCK_LO; g < CFG_W; g++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cfg_q[g] <= 1'b0;
      else if (cfg_we && wr_data[g]) cfg_q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_service.sv
module wdog_service
  import wdog_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY        = 8'h5C,
  parameter logic [DATA_W-1:0] RESET_LOAD = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              key_en,
  input  logic              lock_cnt,
  input  logic              tick,
  output logic              svc_evt,
  output logic [DATA_W-1:0] svc_val,
  output logic              bad_key_evt,
  output logic              early_evt
);
  logic              cnt_ok, key_wr, key_ok;
  logic [DATA_W-1:0] reload_q;
  logic              touched_q;

  function automatic logic key_match(input logic [DATA_W-1:0] d);
    return d == KEY;
  endfunction

  assign cnt_ok      = wr_en && (wr_addr == REG_CNT) && !lock_cnt;
  assign key_wr      = wr_en && (wr_addr == REG_KEY) && key_en;
  assign key_ok      = key_wr && key_match(wr_data);
  assign bad_key_evt = key_wr && !key_match(wr_data);
  assign svc_evt     = cnt_ok || key_ok;
  assign svc_val     = cnt_ok ? wr_data : reload_q;
  assign early_evt   = svc_evt && touched_q && !tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q  <= RESET_LOAD;
      touched_q <= 1'b0;
    end else begin
      if (cnt_ok) reload_q <= wr_data;
      if (svc_evt)   touched_q <= 1'b1;
      else if (tick) touched_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              svc,
  input  logic [DATA_W-1:0] svc_val,
  input  logic              trip,
  output logic              running,
  output logic [DATA_W-1:0] count,
  output logic              fire,
  output logic              zero_evt
);
  function automatic logic [DATA_W-1:0] step_down(input logic [DATA_W-1:0] c);
    return (c <= DATA_W'(1)) ? '0 : c - DATA_W'(1);
  endfunction

  function automatic logic last_step(input logic [DATA_W-1:0] c);
    return c <= DATA_W'(1);
  endfunction

  logic              dec_evt;
  logic [DATA_W-1:0] count_d;

  assign dec_evt  = running && tick && !svc;
  assign zero_evt = dec_evt && last_step(count);

  always_comb begin
    count_d = count;
    if (svc)          count_d = svc_val;
    else if (dec_evt) count_d = step_down(count);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
      fire    <= 1'b0;
    end else begin
      count <= count_d;
      if (svc)             running <= 1'b1;
      if (zero_evt || trip) fire   <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY        = 8'h5C,
  parameter logic [DATA_W-1:0] RESET_LOAD = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wd_fire,
  output logic              wd_running,
  output logic [DATA_W-1:0] wd_count,
  output logic [CFG_W-1:0]  cfg_state
);
  logic              tick_sel, key_en, lock_cnt;
  logic              svc_evt, bad_key_evt, early_evt, zero_evt;
  logic [DATA_W-1:0] svc_val;

  wdog_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (wr_en && (wr_addr == REG_CFG)),
    .wr_data (wr_data),
    .cfg_q   (cfg_state)
  );

  assign tick_sel = cfg_state[CFG_SRC] ? tick_fast : tick_slow;
  assign key_en   = cfg_state[CFG_KEYEN];
  assign lock_cnt = cfg_state[LOCK_CNT];

  wdog_service #(.DATA_W(DATA_W), .KEY(KEY), .RESET_LOAD(RESET_LOAD)) u_svc (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .key_en      (key_en),
    .lock_cnt    (lock_cnt),
    .tick        (tick_sel),
    .svc_evt     (svc_evt),
    .svc_val     (svc_val),
    .bad_key_evt (bad_key_evt),
    .early_evt   (early_evt)
  );

  wdog_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_sel),
    .svc      (svc_evt),
    .svc_val  (svc_val),
    .trip     (bad_key_evt || early_evt),
    .running  (wd_running),
    .count    (wd_count),
    .fire     (wd_fire),
    .zero_evt (zero_evt)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY    = 8'h5C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wd_fire,
  input logic              wd_running,
  input logic [DATA_W-1:0] wd_count,
  input logic              tick_sel,
  input logic              key_en,
  input logic              lock_cnt,
  input logic              svc_evt,
  input logic              early_evt,
  input logic              zero_evt
);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_running |-> wd_count == '0);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_running && tick_sel && !svc_evt && wd_count > DATA_W'(1))
      |=> wd_count == $past(wd_count) - DATA_W'(1));

  p_zero_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_running && tick_sel && !svc_evt && wd_count <= DATA_W'(1))
      |=> (wd_fire && wd_count == '0));

  p_zero_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> wd_fire);

  p_bad_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_KEY && key_en && wr_data != KEY) |=> wd_fire);

  p_key_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_KEY && !key_en && !wd_running && !wd_fire)
      |=> (!wd_running && !wd_fire));

  p_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
    early_evt |=> wd_fire);

  p_fire_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> wd_fire);

  p_run_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_running |=> wd_running);

  p_cnt_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_CNT && lock_cnt && !wd_running) |=> !wd_running);
endmodule

bind wdog_keyed wdog_keyed_chk #(.DATA_W(DATA_W), .KEY(KEY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wd_fire    (wd_fire),
  .wd_running (wd_running),
  .wd_count   (wd_count),
  .tick_sel   (tick_sel),
  .key_en     (key_en),
  .lock_cnt   (lock_cnt),
  .svc_evt    (svc_evt),
  .early_evt  (early_evt),
  .zero_evt   (zero_evt)
);

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LOAD0 = 8'd6;
  localparam logic [7:0] KEYV  = 8'h5C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_fast = 1'b0, tick_slow = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd3;
  logic [7:0] wr_data = '0;
  logic       wd_fire, wd_running;
  logic [7:0] wd_count;
  logic [6:0] cfg_state;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";

  // behavioural reference state
  logic [6:0] m_cfg;
  logic [7:0] m_reload, m_cnt;
  bit         m_run, m_fire, m_touch;

  wdog_keyed #(.DATA_W(8), .KEY(KEYV), .RESET_LOAD(LOAD0)) i_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wd_fire(wd_fire), .wd_running(wd_running), .wd_count(wd_count),
    .cfg_state(cfg_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = '0; m_reload = LOAD0; m_cnt = '0;
      m_run = 0; m_fire = 0; m_touch = 0;
    end else begin
      bit tk, svc, cnt_w, key_w;
      logic [7:0] nv;
      tk    = m_cfg[0] ? tick_fast : tick_slow;
      cnt_w = wr_en && wr_addr == 2'd1 && !m_cfg[6];
      key_w = wr_en && wr_addr == 2'd2 && m_cfg[1];
      svc   = cnt_w || (key_w && wr_data == KEYV);
      nv    = cnt_w ? wr_data : m_reload;
      if (key_w && wr_data != KEYV) m_fire = 1;
      if (svc && m_touch && !tk)    m_fire = 1;
      if (svc) begin
        m_cnt = nv; m_run = 1;
      end else if (m_run && tk) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_fire = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (svc) m_touch = 1; else if (tk) m_touch = 0;
      if (cnt_w) m_reload = wr_data;
      if (wr_en && wr_addr == 2'd0 && !m_cfg[2])
        m_cfg = {m_cfg[6:2] | wr_data[6:2], wr_data[1:0]};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (wd_fire !== m_fire || wd_running !== m_run ||
          wd_count !== m_cnt || cfg_state !== m_cfg) begin
        fails++;
        $display("FAIL %s model: fire/run/cnt/cfg %0b/%0b/%0d/%h exp %0b/%0b/%0d/%h",
                 phase, wd_fire, wd_running, wd_count, cfg_state,
                 m_fire, m_run, m_cnt, m_cfg);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles %0d exp below 20000", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_addr = 2'd3;
  endtask

  task automatic tick(input bit fast);
    @(negedge clk);
    if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
    @(negedge clk); tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    phase = "R1";
    chk("R1 running", wd_running, 0); chk("R1 fire", wd_fire, 0);
    chk("R1 count", wd_count, 0);     chk("R1 cfg", cfg_state, 0);

    phase = "R2";
    wr(2'd0, 8'h00); wr(2'd1, 8'd5);
    chk("R2 running", wd_running, 1); chk("R2 count", wd_count, 5);
    phase = "R4";
    tick(1); chk("R4 unselected fast tick", wd_count, 5);
    phase = "R3";
    tick(0); chk("R3 slow tick step", wd_count, 4);

    phase = "R8";
    wr(2'd2, KEYV);  chk("R8 key off count", wd_count, 4);
    wr(2'd2, 8'h33); chk("R8 key off fire", wd_fire, 0);

    phase = "R6";
    wr(2'd0, 8'h03); chk("R4 cfg", cfg_state, 3);
    tick(0); chk("R4 unselected slow tick", wd_count, 4);
    tick(1); chk("R3 fast tick step", wd_count, 3);
    wr(2'd2, KEYV); chk("R6 key reload", wd_count, 5); chk("R6 no fire", wd_fire, 0);
    tick(1); wr(2'd2, KEYV); chk("R6 second service", wd_count, 5);
    phase = "R9";
    wr(2'd2, KEYV); chk("R9 early service", wd_fire, 1);

    phase = "R7";
    do_reset(); wr(2'd0, 8'h02); wr(2'd2, 8'h11);
    chk("R7 bad key fire", wd_fire, 1); chk("R7 stays idle", wd_running, 0);

    phase = "R6";
    do_reset(); wr(2'd0, 8'h02); wr(2'd2, KEYV);
    chk("R6 idle start", wd_running, 1); chk("R6 reset reload", wd_count, LOAD0);

    phase = "R5";
    do_reset(); wr(2'd0, 8'h01); wr(2'd1, 8'd3);
    tick(1); tick(1); chk("R5 at one", wd_count, 1); chk("R5 not yet", wd_fire, 0);
    tick(1); chk("R5 zero fire", wd_fire, 1); chk("R5 zero count", wd_count, 0);
    phase = "R10";
    tick(1); wr(2'd0, 8'h00); tick(0);
    chk("R10 fire sticky", wd_fire, 1); chk("R10 run sticky", wd_running, 1);

    phase = "R5";
    do_reset(); wr(2'd0, 8'h01); wr(2'd1, 8'd0);
    chk("R5 load zero", wd_fire, 0);
    tick(1); chk("R5 zero load fire", wd_fire, 1);

    phase = "R11";
    do_reset(); wr(2'd0, 8'h40); wr(2'd0, 8'h00);
    chk("R11 lock set only", cfg_state, 8'h40);
    wr(2'd1, 8'd9);
    chk("R11 locked count idle", wd_running, 0); chk("R11 locked count", wd_count, 0);
    wr(2'd0, 8'h05); wr(2'd0, 8'h02);
    chk("R11 cfg lock", cfg_state, 8'h45);

    repeat (2) @(negedge clk);
    report();
  end
endmodule